// File: doc/BRIEF.md
# Power-on reset time-out sequencer

This block decides when a microcontroller core may leave reset after power comes up, after a brown-out, or when the device wakes from a power-managed mode. It chains up to three waits. The first is a power-up delay counted on the internal RC clock. The second is an oscillator settling delay counted on the external oscillator clock. The third is a PLL lock delay, which is again counted on the RC clock. The oscillator mode and a configuration bit decide which of these waits run. The sequence controller lives in the RC domain. The oscillator settling counter lives in the oscillator domain, and the two talk through a four-phase request/done handshake over two-flop synchronizers.

The external reset pin (active low) is ANDed onto the release. Holding the pin low does not stop the timers, so a pin held low for longer than the whole sequence lets the core run as soon as the pin rises. A new power-on or brown-out event restarts the sequence from the start at any point. All pins are plain control and status signals. Nothing here carries a data stream, so there is no valid/ready interface.

Top module: `por_timeout_seq`

## Requirements
- R1: While `por_evt` is high, `core_rst` is 1 and `pwrt_busy`, `ost_busy` and `pll_busy` are all 0.
- R2: After `por_evt` falls with `pwrt_dis` = 0, `pwrt_busy` is high for exactly PWRT_TICKS RC cycles, and `core_rst` stays 1 during every active phase.
- R3: With `pwrt_dis` = 1, a power-on sequence never raises `pwrt_busy`.
- R4: Mode encoding on `osc_mode`: 0 = crystal, 1 = crystal with PLL, 2 = external clock, 3 = external clock with PLL, 4 = internal RC, 5 = internal RC core clock with a crystal, 6 and 7 = treated as 4. Modes 0, 1 and 5 run the oscillator settling phase (`ost_busy`) of OST_CYCLES oscillator cycles after the power-up delay. No other mode runs it.
- R5: Modes 1 and 3 run the PLL lock phase (`pll_busy`) of PLL_TICKS RC cycles as the last phase. No other mode runs it.
- R6: In modes 2, 4, 6 and 7 with `pwrt_dis` = 1, `core_rst` falls within 3 RC cycles of `por_evt` falling.
- R7: A rising edge on `pm_wake` while the core runs starts a sequence without the power-up delay, running only the phases of R4 and R5 that the mode needs. In a mode that needs neither, `core_rst` stays 0.
- R8: If `mclr_n` is held low through a whole power-on sequence, the timers still run to completion, and `core_rst` falls within 3 RC cycles of `mclr_n` rising.
- R9: Driving `mclr_n` low after release sets `core_rst` within 3 RC cycles and starts no timer phase. Raising it again releases the core within 3 cycles.
- R10: A new `por_evt` pulse during the oscillator settling phase restarts the sequence, with the power-up delay again.
- R11: `osc_mode` is sampled once when a sequence starts. Changes to it during a running sequence do not alter which phases run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Internal RC clock; runs the sequencer and the power-up and PLL delays |
| osc_clk | input | 1 | External oscillator clock; runs the settling counter |
| por_evt | input | 1 | Power-on / brown-out event, active high, asynchronous |
| pm_wake | input | 1 | Request to exit a power-managed mode, asynchronous level; its rising edge acts |
| mclr_n | input | 1 | External reset pin, active low, asynchronous |
| osc_mode | input | 3 | Oscillator mode select (encoding in R4) |
| pwrt_dis | input | 1 | 1 disables the power-up delay |
| core_rst | output | 1 | Holds the core in reset when 1 |
| pwrt_busy | output | 1 | Power-up delay phase active |
| ost_busy | output | 1 | Oscillator settling phase active, including its handshake return |
| pll_busy | output | 1 | PLL lock phase active |

## Verification
The hardest case to reach is a second power-on event that lands while the settling counter is running in the other clock domain. The handshake has to unwind cleanly, and the next sequence must not see a stale done flag. The bench releases a crystal-mode sequence and counts a fixed number of RC cycles until it has seen `ost_busy` high. It then pulses `por_evt` again and checks that a full sequence with the power-up delay follows. Both clocks run at unrelated periods, so the sequence lengths are checked against windows that are computed from the parameters plus the synchronizer latency.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_START,
    ST_PWRT,
    ST_OST,
    ST_OST_CLR,
    ST_PLL,
    ST_DONE
  } seq_state_t;

  localparam logic [2:0] MODE_XTAL     = 3'd0;
  localparam logic [2:0] MODE_XTAL_PLL = 3'd1;
  localparam logic [2:0] MODE_EXT      = 3'd2;
  localparam logic [2:0] MODE_EXT_PLL  = 3'd3;
  localparam logic [2:0] MODE_INT      = 3'd4;
  localparam logic [2:0] MODE_INT_XTAL = 3'd5;

  // crystal-driven modes need the settling delay
  function automatic logic mode_needs_ost(input logic [2:0] m);
    return (m == MODE_XTAL) || (m == MODE_XTAL_PLL) || (m == MODE_INT_XTAL);
  endfunction

  function automatic logic mode_needs_pll(input logic [2:0] m);
    return (m == MODE_XTAL_PLL) || (m == MODE_EXT_PLL);
  endfunction

endpackage

// File: rtl/rst_seq_rsync.sv
// Reset synchronizer: asynchronous assert, synchronous release.
module rst_seq_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= '1;
    else      chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst = chain[STAGES-1];
endmodule

// File: rtl/rst_seq_bsync.sv
// Level synchronizer for a single control bit.
module rst_seq_bsync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rst_seq_ost.sv
// Oscillator settling counter, oscillator clock domain.
// Four-phase: done rises OST_CYCLES edges after the request is seen,
// and clears once the request is withdrawn.
module rst_seq_ost #(
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int          SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic osc_rst,
  input  logic start_req,
  output logic ost_done
);
  localparam int unsigned   CW   = $clog2(OST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

  logic          req_s;
  logic [CW-1:0] cnt;

  rst_seq_bsync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk(osc_clk), .rst(osc_rst), .d(start_req), .q(req_s)
  );

  always_ff @(posedge osc_clk or posedge osc_rst) begin
    if (osc_rst) begin
      cnt      <= '0;
      ost_done <= 1'b0;
    end else if (!req_s) begin
      cnt      <= '0;
      ost_done <= 1'b0;
    end else if (!ost_done) begin
      if (cnt == LAST) ost_done <= 1'b1;
      else             cnt      <= cnt + 1'b1;
    end
  end

  AST_OST_DROP_CLEARS: assert property (@(posedge osc_clk) disable iff (osc_rst)
    !req_s |=> !ost_done); // R4
  AST_OST_DONE_HOLDS: assert property (@(posedge osc_clk) disable iff (osc_rst)
    (ost_done && req_s) |=> ost_done); // R4
  AST_OST_CNT_RANGE: assert property (@(posedge osc_clk) disable iff (osc_rst)
    cnt <= LAST); // R4
endmodule

// File: rtl/rst_seq_ctrl.sv
// Sequence controller, internal RC clock domain.
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned PWRT_TICKS = 2048,
  parameter int unsigned PLL_TICKS  = 63
) (
  input  logic       rc_clk,
  input  logic       rc_rst,
  input  logic       pwrt_dis,
  input  logic [2:0] osc_mode,
  input  logic       wake_req,
  input  logic       ost_done_s,
  output logic       ost_req,
  output logic       pwrt_busy,
  output logic       ost_busy,
  output logic       pll_busy,
  output logic       seq_done
);
  localparam int unsigned   MAXT      = (PWRT_TICKS > PLL_TICKS) ? PWRT_TICKS : PLL_TICKS;
  localparam int unsigned   TW        = $clog2(MAXT + 1);
  localparam logic [TW-1:0] PWRT_LAST = TW'(PWRT_TICKS - 1);
  localparam logic [TW-1:0] PLL_LAST  = TW'(PLL_TICKS - 1);

  seq_state_t    state, nxt;
  logic [2:0]    mode_q;
  logic [TW-1:0] tick;
  logic          wake_d, wake_rise, mode_ld, counting;

  function automatic seq_state_t post_pwrt(input logic [2:0] m);
    if (mode_needs_ost(m))      return ST_OST;
    else if (mode_needs_pll(m)) return ST_PLL;
    else                        return ST_DONE;
  endfunction

  assign wake_rise = wake_req & ~wake_d;
  assign counting  = (state == ST_PWRT) || (state == ST_PLL);

  always_comb begin
    nxt     = state;
    mode_ld = 1'b0;
    case (state)
      ST_START: begin
        mode_ld = 1'b1;
        nxt     = pwrt_dis ? post_pwrt(osc_mode) : ST_PWRT;
      end
      ST_PWRT:    if (tick == PWRT_LAST) nxt = post_pwrt(mode_q);
      ST_OST:     if (ost_done_s) nxt = ST_OST_CLR;
      ST_OST_CLR: if (!ost_done_s) nxt = mode_needs_pll(mode_q) ? ST_PLL : ST_DONE;
      ST_PLL:     if (tick == PLL_LAST) nxt = ST_DONE;
      ST_DONE: begin
        if (wake_rise) begin
          mode_ld = 1'b1;
          nxt     = post_pwrt(osc_mode);
        end
      end
      default:    nxt = ST_START;
    endcase
  end

  always_ff @(posedge rc_clk or posedge rc_rst) begin
    if (rc_rst) begin
      state  <= ST_START;
      mode_q <= MODE_INT;
      tick   <= '0;
      wake_d <= 1'b0;
    end else begin
      state  <= nxt;
      wake_d <= wake_req;
      if (mode_ld) mode_q <= osc_mode;
      if (nxt != state) tick <= '0;
      else if (counting) tick <= tick + 1'b1;
    end
  end

  assign ost_req   = (state == ST_OST);
  assign pwrt_busy = (state == ST_PWRT);
  assign ost_busy  = (state == ST_OST) || (state == ST_OST_CLR);
  assign pll_busy  = (state == ST_PLL);
  assign seq_done  = (state == ST_DONE);

  AST_PWRT_ONLY_AFTER_POR: assert property (@(posedge rc_clk) disable iff (rc_rst)
    $rose(pwrt_busy) |-> $past(state) == ST_START); // R7
  AST_PWRT_LENGTH: assert property (@(posedge rc_clk) disable iff (rc_rst)
    $fell(pwrt_busy) |-> $past(tick) == PWRT_LAST); // R2
  AST_OST_MODE_MATCH: assert property (@(posedge rc_clk) disable iff (rc_rst)
    ost_busy |-> mode_needs_ost(mode_q)); // R4
  AST_PLL_MODE_MATCH: assert property (@(posedge rc_clk) disable iff (rc_rst)
    pll_busy |-> mode_needs_pll(mode_q)); // R5
  AST_MODE_STABLE: assert property (@(posedge rc_clk) disable iff (rc_rst)
    (state != ST_START && state != ST_DONE) |=> $stable(mode_q)); // R11
endmodule

// File: rtl/por_timeout_seq.sv
module por_timeout_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned PWRT_TICKS  = 2048,
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int unsigned PLL_TICKS   = 63,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       rc_clk,
  input  logic       osc_clk,
  input  logic       por_evt,
  input  logic       pm_wake,
  input  logic       mclr_n,
  input  logic [2:0] osc_mode,
  input  logic       pwrt_dis,
  output logic       core_rst,
  output logic       pwrt_busy,
  output logic       ost_busy,
  output logic       pll_busy
);
  localparam int RUNW = $clog2(SYNC_STAGES + 2);

  logic rc_rst, osc_rst;
  logic mclr_s, wake_s, done_s;
  logic ost_req, ost_done, seq_done;

  rst_seq_rsync #(.STAGES(SYNC_STAGES)) u_rc_rst (
    .clk(rc_clk), .arst(por_evt), .rst(rc_rst)
  );
  rst_seq_rsync #(.STAGES(SYNC_STAGES)) u_osc_rst (
    .clk(osc_clk), .arst(por_evt), .rst(osc_rst)
  );

  rst_seq_bsync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mclr_sync (
    .clk(rc_clk), .rst(rc_rst), .d(mclr_n), .q(mclr_s)
  );
  rst_seq_bsync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wake_sync (
    .clk(rc_clk), .rst(rc_rst), .d(pm_wake), .q(wake_s)
  );
  rst_seq_bsync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
    .clk(rc_clk), .rst(rc_rst), .d(ost_done), .q(done_s)
  );

  rst_seq_ctrl #(.PWRT_TICKS(PWRT_TICKS), .PLL_TICKS(PLL_TICKS)) u_ctrl (
    .rc_clk(rc_clk), .rc_rst(rc_rst), .pwrt_dis(pwrt_dis), .osc_mode(osc_mode),
    .wake_req(wake_s), .ost_done_s(done_s), .ost_req(ost_req),
    .pwrt_busy(pwrt_busy), .ost_busy(ost_busy), .pll_busy(pll_busy),
    .seq_done(seq_done)
  );

  rst_seq_ost #(.OST_CYCLES(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ost (
    .osc_clk(osc_clk), .osc_rst(osc_rst), .start_req(ost_req), .ost_done(ost_done)
  );

  // the pin gates the release only; it never restarts a phase
  assign core_rst = ~(seq_done & mclr_s);

  // consecutive low samples of the pin, for the response check
  logic [RUNW-1:0] pin_low_run;
  always_ff @(posedge rc_clk or posedge rc_rst) begin
    if (rc_rst)                                pin_low_run <= '0;
    else if (mclr_n)                           pin_low_run <= '0;
    else if (pin_low_run != RUNW'(SYNC_STAGES)) pin_low_run <= pin_low_run + 1'b1;
  end

  AST_PIN_LOW_HOLDS: assert property (@(posedge rc_clk) disable iff (rc_rst)
    (pin_low_run == RUNW'(SYNC_STAGES)) |-> core_rst); // R9
  AST_HELD_IN_PHASES: assert property (@(posedge rc_clk) disable iff (rc_rst)
    (pwrt_busy || ost_busy || pll_busy) |-> core_rst); // R2
  AST_ONE_PHASE: assert property (@(posedge rc_clk) disable iff (rc_rst)
    $onehot0({pwrt_busy, ost_busy, pll_busy})); // R2
endmodule

// File: tb/por_timeout_seq_test.sv
`timescale 1ns/1ps
module por_timeout_seq_test;
  localparam int PW = 12;
  localparam int OC = 20;
  localparam int PL = 9;
  localparam int OST_RC = OC * 10 / 4;   // settling delay in RC cycles
  localparam int OST_SLACK = 36;

  logic rc_clk = 1'b0, osc_clk = 1'b0;
  logic por_evt = 1'b1, pm_wake = 1'b0, mclr_n = 1'b1, pwrt_dis = 1'b0;
  logic [2:0] osc_mode = 3'd0;
  logic core_rst, pwrt_busy, ost_busy, pll_busy;

  int n_chk = 0, n_fail = 0;
  int obs_hold;
  bit obs_p, obs_o, obs_l, fin = 1'b0;

  always #2 rc_clk = ~rc_clk;
  always #5 osc_clk = ~osc_clk;

  por_timeout_seq #(.PWRT_TICKS(PW), .OST_CYCLES(OC), .PLL_TICKS(PL)) uut (
    .rc_clk(rc_clk), .osc_clk(osc_clk), .por_evt(por_evt), .pm_wake(pm_wake),
    .mclr_n(mclr_n), .osc_mode(osc_mode), .pwrt_dis(pwrt_dis),
    .core_rst(core_rst), .pwrt_busy(pwrt_busy), .ost_busy(ost_busy), .pll_busy(pll_busy)
  );

  function automatic bit e_ost(input int m);
    return (m == 0) || (m == 1) || (m == 5);
  endfunction
  function automatic bit e_pll(input int m);
    return (m == 1) || (m == 3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic observe(input int cyc);
    obs_hold = 0; obs_p = 0; obs_o = 0; obs_l = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge rc_clk);
      if (core_rst)  obs_hold++;
      if (pwrt_busy) obs_p = 1;
      if (ost_busy)  obs_o = 1;
      if (pll_busy)  obs_l = 1;
    end
  endtask

  task automatic por_pulse();
    @(negedge rc_clk);
    por_evt = 1'b1;
    repeat (3) @(negedge rc_clk);
    chk(core_rst === 1'b1 && {pwrt_busy, ost_busy, pll_busy} === 3'b000, "R1",
        {core_rst, pwrt_busy, ost_busy, pll_busy}, 4'b1000);
    por_evt = 1'b0;
  endtask

  task automatic por_run(input int m, input bit dis);
    @(negedge rc_clk);
    osc_mode = 3'(m);
    pwrt_dis = dis;
    por_pulse();
    observe(200);
  endtask

  initial begin
    repeat (100000) @(posedge rc_clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lo, hi, h1;
    bit p1, o1, l1;
    repeat (4) @(negedge rc_clk);
    chk(core_rst === 1'b1 && {pwrt_busy, ost_busy, pll_busy} === 3'b000, "R1",
        core_rst, 1);
    por_evt = 1'b0;
    observe(200);

    // power-on sweep over every mode and both settings of the enable bit
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 2; d++) begin
        por_run(m, d[0]);
        lo = 2 + (d ? 0 : PW) + (e_ost(m) ? OST_RC : 0) + (e_pll(m) ? PL : 0);
        hi = lo + 6 + (e_ost(m) ? OST_SLACK : 0);
        chk(obs_p == !d[0], d ? "R3" : "R2", obs_p, !d[0]);
        chk(obs_o == e_ost(m), "R4", obs_o, e_ost(m));
        chk(obs_l == e_pll(m), "R5", obs_l, e_pll(m));
        rng((d && !e_ost(m) && !e_pll(m)) ? "R6" : "R2", obs_hold, lo, hi);
        chk(core_rst === 1'b0, "R2", core_rst, 0);
      end
    end

    // wake from a power-managed mode, every mode
    for (int m = 0; m < 8; m++) begin
      por_run(m, 1'b1);
      @(negedge rc_clk);
      pm_wake = 1'b1;
      observe(150);
      pm_wake = 1'b0;
      lo = (e_ost(m) ? OST_RC : 0) + (e_pll(m) ? PL : 0);
      hi = (lo == 0) ? 0 : lo + 4 + (e_ost(m) ? OST_SLACK : 0);
      chk(obs_p == 0, "R7", obs_p, 0);
      chk(obs_o == e_ost(m), "R7", obs_o, e_ost(m));
      chk(obs_l == e_pll(m), "R7", obs_l, e_pll(m));
      rng("R7", obs_hold, lo, hi);
      observe(5);
    end

    // mode change during the power-up delay is ignored
    @(negedge rc_clk);
    osc_mode = 3'd4;
    pwrt_dis = 1'b0;
    por_pulse();
    observe(5);
    h1 = obs_hold; p1 = obs_p; o1 = obs_o; l1 = obs_l;
    osc_mode = 3'd1;
    observe(200);
    chk(!(o1 || obs_o || l1 || obs_l), "R11", {o1 | obs_o, l1 | obs_l}, 0);
    chk(p1 == 1'b1, "R11", p1, 1);
    rng("R11", h1 + obs_hold, 2 + PW, 2 + PW + 6);

    // second power-on event while the settling counter runs
    @(negedge rc_clk);
    osc_mode = 3'd0;
    pwrt_dis = 1'b0;
    por_pulse();
    observe(30);
    chk(ost_busy === 1'b1, "R10", ost_busy, 1);
    por_pulse();
    observe(200);
    chk(obs_p == 1'b1, "R10", obs_p, 1);
    rng("R10", obs_hold, 2 + PW + OST_RC, 2 + PW + OST_RC + 6 + OST_SLACK);

    // pin held low across a full sequence
    mclr_n = 1'b0;
    por_run(1, 1'b0);
    chk(obs_hold == 200, "R8", obs_hold, 200);
    chk(obs_p && obs_o && obs_l, "R8", {obs_p, obs_o, obs_l}, 3'b111);
    mclr_n = 1'b1;
    observe(10);
    rng("R8", obs_hold, 1, 3);
    chk(!(obs_p || obs_o || obs_l), "R8", {obs_p, obs_o, obs_l}, 0);

    // pin pulled low after release
    mclr_n = 1'b0;
    observe(20);
    rng("R9", obs_hold, 17, 20);
    chk(!(obs_p || obs_o || obs_l), "R9", {obs_p, obs_o, obs_l}, 0);
    mclr_n = 1'b1;
    observe(10);
    rng("R9", obs_hold, 1, 3);
    chk(core_rst === 1'b0, "R9", core_rst, 0);

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule